// File: doc/BRIEF.md
# Adaptive Warp Batch Issuer

This block sits between a producer of 32-bit packet descriptors and a pool of parallel processing engines. Descriptors are pushed into a circular task queue. The block chooses when to hand a batch of queued work to the warp allocator. Each batch is a whole number of 32-descriptor warps. The choice depends on four things: how many descriptors are waiting, a programmable batch threshold counted in warps, a countdown timeout, and how many execution slots the engines report as free.

When the threshold is reached, the block releases as many whole warps as the free slots allow. If too few warps have gathered, the timeout releases what is already whole. If less than one warp is waiting, the timeout releases that short group as one padded warp, and the issue count acts as its valid mask. A batch is described by its base queue index, its descriptor count, its warp count and the warp id the allocator granted. It is offered over a valid/ready handshake. Queue entries are freed only when the handshake completes. Engines fetch descriptors by index through a registered read port.

A small threshold gives lower packet delay but more fetch requests. A large threshold cuts the scheduling work but makes each packet wait longer.

Top module: `pkt_batch_issuer`

## Requirements
- R1: Each accepted descriptor is stored at the next queue index in arrival order, starting from index 0 after reset. Driving `rd_addr` returns that entry on `rd_data` one clock later.
- R2: `wr_ready` is low exactly when the queue holds DEPTH entries. A write offered while it is low is dropped and adds one to `ovf_count`, which saturates at all ones. `wr_ready` rises again once a handshake frees entries.
- R3: No batch is launched while `free_slots` is zero, even with a full queue.
- R4: When the number of whole waiting warps is at least `cfg_thresh`, a batch is launched on the next clock. A threshold of 0 acts as 1. The batch has `issue_nwarps` = min(whole warps, `free_slots`) and `issue_count` = 32 × `issue_nwarps`. Below the threshold, and before the timeout, nothing is launched.
- R5: If fewer than 32 descriptors are waiting, they are launched only after the timeout. Such a batch has `issue_count` equal to the number waiting and `issue_nwarps` = 1.
- R6: Once the queue has been non-empty, with no batch pending, for `cfg_timeout` cycles, any whole warps are launched even below the threshold. The leftover partial warp stays queued.
- R7: While `issue_valid` is high and `issue_ready` is low, the valid flag and all issue fields hold their values.
- R8: A handshake advances the queue head by `issue_count`, modulo DEPTH. The next batch's `issue_base` is the previous base plus the previous count.
- R9: `issue_warp_id` carries the `alloc_warp_id` value present in the cycle the batch was launched.
- R10: After reset, `issue_valid` is low, `wr_ready` is high and `ovf_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Descriptor write request |
| wr_data | input | 32 | Descriptor word |
| wr_ready | output | 1 | Queue can accept a descriptor |
| ovf_count | output | 16 | Saturating count of dropped writes |
| cfg_thresh | input | 6 | Batch threshold in warps (0 acts as 1) |
| cfg_timeout | input | 16 | Waiting cycles before a forced launch |
| free_slots | input | 6 | Free warp slots in the engine pool |
| alloc_warp_id | input | 8 | Warp id offered by the allocator |
| issue_valid | output | 1 | Batch request pending |
| issue_ready | input | 1 | Allocator accepts the batch |
| issue_base | output | 11 | Queue index of the first descriptor in the batch |
| issue_count | output | 11 | Number of valid descriptors in the batch |
| issue_nwarps | output | 6 | Number of warps in the batch |
| issue_warp_id | output | 8 | Granted warp id for the batch |
| rd_addr | input | 11 | Engine read index |
| rd_data | output | 32 | Descriptor at rd_addr, one cycle later |

## Verification
Several situations are hard to reach from the ports: a batch whose size is limited by free slots rather than by queue depth, a threshold that has not yet been met, and the hold of a batch under backpressure. Free-running arrivals would trigger a launch part-way through filling, so the stimulus first loads the queue with `free_slots` at zero and only then opens the slots. Each case therefore starts from an exact, known occupancy. The padded short warp and the sub-threshold timeout are checked by confirming silence well before the timeout and a launch after it. Overflow is reached by filling all 1028 entries while launches are blocked.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  // Reason a launch is taken in a given cycle.
  typedef enum logic [1:0] {
    FIRE_NONE    = 2'd0,
    FIRE_THRESH  = 2'd1,
    FIRE_TIMEOUT = 2'd2
  } fire_e;
endpackage

// File: rtl/pbi_desc_ram.sv
module pbi_desc_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1028,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbi_queue_ctrl.sv
module pbi_queue_ctrl #(
  parameter int DEPTH  = 1028,
  parameter int OVF_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             pop,
  input  logic [OCC_W-1:0] pop_cnt,
  output logic             wr_ready,
  output logic             we,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic [OCC_W-1:0] occ,
  output logic [OVF_W-1:0] ovf_count
);
  logic [IDX_W:0]   head_sum;
  logic [OCC_W-1:0] sub_amt;

  assign wr_ready = (occ != OCC_W'(DEPTH));
  assign we       = wr_valid && wr_ready;
  assign head_sum = {1'b0, head} + (IDX_W+1)'(pop_cnt);
  assign sub_amt  = pop ? pop_cnt : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail      <= '0;
      head      <= '0;
      occ       <= '0;
      ovf_count <= '0;
    end else begin
      if (we) tail <= (tail == IDX_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
      if (pop)
        head <= (head_sum >= (IDX_W+1)'(DEPTH)) ? IDX_W'(head_sum - (IDX_W+1)'(DEPTH))
                                                : IDX_W'(head_sum);
      occ <= occ + OCC_W'(we) - sub_amt;
      if (wr_valid && !wr_ready && (ovf_count != '1)) ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/pbi_launch_ctrl.sv
module pbi_launch_ctrl
  import pbi_pkg::*;
#(
  parameter int DEPTH  = 1028,
  parameter int WARP   = 32,
  parameter int SLOT_W = 6,
  parameter int WID_W  = 8,
  parameter int TMO_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OCC_W-1:0]  occ,
  input  logic [IDX_W-1:0]  head,
  input  logic [SLOT_W-1:0] free_slots,
  input  logic [SLOT_W-1:0] thresh,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [WID_W-1:0]  alloc_warp_id,
  input  logic              issue_ready,
  output logic              issue_valid,
  output logic [IDX_W-1:0]  issue_base,
  output logic [OCC_W-1:0]  issue_count,
  output logic [SLOT_W-1:0] issue_nwarps,
  output logic [WID_W-1:0]  issue_warp_id,
  output logic              pop,
  output logic [OCC_W-1:0]  pop_cnt
);
  logic [OCC_W-1:0]  whole, free_ext, thr_ext, nw_pick, cnt_nxt;
  logic [SLOT_W-1:0] nw_nxt;
  logic [TMO_W-1:0]  tmr;
  logic              expired;
  fire_e             fire;

  assign pop     = issue_valid && issue_ready;
  assign pop_cnt = issue_count;

  always_comb begin
    whole    = occ / OCC_W'(WARP);
    free_ext = OCC_W'(free_slots);
    thr_ext  = (thresh == '0) ? OCC_W'(1) : OCC_W'(thresh);
    nw_pick  = (whole < free_ext) ? whole : free_ext;
    expired  = (tmr >= tmo_limit);

    if (issue_valid || (free_slots == '0) || (occ == '0)) fire = FIRE_NONE;
    else if (whole >= thr_ext)                            fire = FIRE_THRESH;
    else if (expired)                                     fire = FIRE_TIMEOUT;
    else                                                  fire = FIRE_NONE;

    if (whole != '0) begin
      nw_nxt  = SLOT_W'(nw_pick);
      cnt_nxt = OCC_W'(nw_pick * OCC_W'(WARP));
    end else begin
      nw_nxt  = SLOT_W'(1);
      cnt_nxt = occ;            // padded short warp, count acts as mask
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr           <= '0;
      issue_valid   <= 1'b0;
      issue_base    <= '0;
      issue_count   <= '0;
      issue_nwarps  <= '0;
      issue_warp_id <= '0;
    end else begin
      if ((fire != FIRE_NONE) || issue_valid || (occ == '0)) tmr <= '0;
      else if (tmr != '1)                                    tmr <= tmr + 1'b1;

      if (pop) issue_valid <= 1'b0;
      else if (fire != FIRE_NONE) begin
        issue_valid   <= 1'b1;
        issue_base    <= head;
        issue_count   <= cnt_nxt;
        issue_nwarps  <= nw_nxt;
        issue_warp_id <= alloc_warp_id;
      end
    end
  end
endmodule

// File: rtl/pkt_batch_issuer.sv
module pkt_batch_issuer #(
  parameter int DW     = 32,
  parameter int DEPTH  = 1028,
  parameter int WARP   = 32,
  parameter int SLOT_W = 6,
  parameter int WID_W  = 8,
  parameter int TMO_W  = 16,
  parameter int OVF_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ready,
  output logic [OVF_W-1:0]  ovf_count,
  input  logic [SLOT_W-1:0] cfg_thresh,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [SLOT_W-1:0] free_slots,
  input  logic [WID_W-1:0]  alloc_warp_id,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [IDX_W-1:0]  issue_base,
  output logic [OCC_W-1:0]  issue_count,
  output logic [SLOT_W-1:0] issue_nwarps,
  output logic [WID_W-1:0]  issue_warp_id,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic             we, pop;
  logic [IDX_W-1:0] tail, head;
  logic [OCC_W-1:0] occ, pop_cnt;

  pbi_queue_ctrl #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_q (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .pop(pop), .pop_cnt(pop_cnt),
    .wr_ready(wr_ready), .we(we), .tail(tail), .head(head), .occ(occ),
    .ovf_count(ovf_count)
  );

  pbi_desc_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(tail), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pbi_launch_ctrl #(.DEPTH(DEPTH), .WARP(WARP), .SLOT_W(SLOT_W), .WID_W(WID_W),
                    .TMO_W(TMO_W)) u_lc (
    .clk(clk), .rst(rst), .occ(occ), .head(head), .free_slots(free_slots),
    .thresh(cfg_thresh), .tmo_limit(cfg_timeout), .alloc_warp_id(alloc_warp_id),
    .issue_ready(issue_ready), .issue_valid(issue_valid), .issue_base(issue_base),
    .issue_count(issue_count), .issue_nwarps(issue_nwarps),
    .issue_warp_id(issue_warp_id), .pop(pop), .pop_cnt(pop_cnt)
  );
endmodule

// File: rtl/pkt_batch_issuer_chk.sv
module pkt_batch_issuer_chk #(
  parameter int DEPTH  = 1028,
  parameter int WARP   = 32,
  parameter int SLOT_W = 6,
  parameter int WID_W  = 8,
  parameter int OVF_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [OVF_W-1:0]  ovf_count,
  input logic [SLOT_W-1:0] free_slots,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [IDX_W-1:0]  issue_base,
  input logic [OCC_W-1:0]  issue_count,
  input logic [SLOT_W-1:0] issue_nwarps,
  input logic [WID_W-1:0]  issue_warp_id
);
  // R7: a pending batch holds under backpressure
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !issue_ready |=> issue_valid && $stable(issue_base) &&
      $stable(issue_count) && $stable(issue_nwarps) && $stable(issue_warp_id));

  // R3: a launch needs a free slot in the cycle it is taken
  p_free_slot_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(issue_valid) |-> $past(free_slots) != '0);

  // R4: full-size batches are whole warps
  p_whole_r4: assert property (@(posedge clk) disable iff (rst)
    issue_valid && (issue_count >= OCC_W'(WARP)) |->
      issue_count == OCC_W'(issue_nwarps) * OCC_W'(WARP));

  // R5: a short batch is one padded, non-empty warp
  p_partial_r5: assert property (@(posedge clk) disable iff (rst)
    issue_valid && (issue_count < OCC_W'(WARP)) |->
      issue_nwarps == SLOT_W'(1) && issue_count != '0);

  // R2: a refused write is counted
  p_drop_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready && (ovf_count != '1) |=> ovf_count == $past(ovf_count) + 1'b1);
endmodule

bind pkt_batch_issuer pkt_batch_issuer_chk #(
  .DEPTH(DEPTH), .WARP(WARP), .SLOT_W(SLOT_W), .WID_W(WID_W), .OVF_W(OVF_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ovf_count(ovf_count), .free_slots(free_slots), .issue_valid(issue_valid),
  .issue_ready(issue_ready), .issue_base(issue_base), .issue_count(issue_count),
  .issue_nwarps(issue_nwarps), .issue_warp_id(issue_warp_id)
);

// File: tb/sim_pkt_batch_issuer.sv
`timescale 1ns/1ps
module sim_pkt_batch_issuer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic [15:0] ovf_count;
  logic [5:0]  cfg_thresh = 6'd1;
  logic [15:0] cfg_timeout = 16'hFFFF;
  logic [5:0]  free_slots = '0;
  logic [7:0]  alloc_warp_id = '0;
  logic        issue_valid;
  logic        issue_ready = 1'b0;
  logic [10:0] issue_base;
  logic [10:0] issue_count;
  logic [5:0]  issue_nwarps;
  logic [7:0]  issue_warp_id;
  logic [10:0] rd_addr = '0;
  logic [31:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  int seq = 0;
  logic got;

  always #5 clk = ~clk;

  pkt_batch_issuer u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .ovf_count(ovf_count), .cfg_thresh(cfg_thresh), .cfg_timeout(cfg_timeout),
    .free_slots(free_slots), .alloc_warp_id(alloc_warp_id), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .issue_base(issue_base), .issue_count(issue_count),
    .issue_nwarps(issue_nwarps), .issue_warp_id(issue_warp_id),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // rows: descriptors written, threshold, free slots, expected count (0 = no launch)
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{32,  1, 4, 32},
    '{96,  2, 4, 96},
    '{96,  2, 1, 32},
    '{40,  0, 2, 32},
    '{63,  2, 4, 0},
    '{128, 3, 2, 64}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_valid = 1'b0; issue_ready = 1'b0; free_slots = '0;
    cfg_thresh = 6'd1; cfg_timeout = 16'hFFFF; alloc_warp_id = '0; seq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = 32'hC0DE_0000 + 32'(seq);
      @(negedge clk);
      seq++;
    end
    wr_valid = 1'b0;
  endtask

  task automatic wait_issue(input int lim, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (issue_valid) seen = 1'b1;
    end
  endtask

  task automatic read_at(input int idx, output logic [31:0] d);
    rd_addr = 11'(idx);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R10: reset state
    chk("R10 issue_valid", 32'(issue_valid), 32'd0);
    chk("R10 wr_ready", 32'(wr_ready), 32'd1);
    chk("R10 ovf_count", 32'(ovf_count), 32'd0);

    // R4 table: load with slots closed, then open slots
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_thresh = 6'(VEC[v][1]);
      push(VEC[v][0]);
      free_slots = 6'(VEC[v][2]);
      wait_issue(50, got);
      if (VEC[v][3] == 0) chk("R4 below threshold silent", 32'(got), 32'd0);
      else begin
        chk("R4 launched", 32'(got), 32'd1);
        chk("R4 count", 32'(issue_count), 32'(VEC[v][3]));
        chk("R4 nwarps", 32'(issue_nwarps), 32'(VEC[v][3] / 32));
      end
    end

    // R5: short warp only after timeout, then R1 readback
    do_reset();
    cfg_timeout = 16'd20; free_slots = 6'd1;
    push(5);
    repeat (8) @(negedge clk);
    chk("R5 no early launch", 32'(issue_valid), 32'd0);
    wait_issue(40, got);
    chk("R5 launched", 32'(got), 32'd1);
    chk("R5 count", 32'(issue_count), 32'd5);
    chk("R5 nwarps", 32'(issue_nwarps), 32'd1);
    read_at(int'(issue_base), d);
    chk("R1 first entry", d, 32'hC0DE_0000);

    // R6: timeout releases whole warps below threshold
    do_reset();
    cfg_thresh = 6'd3; cfg_timeout = 16'd20;
    push(40);
    free_slots = 6'd2;
    wait_issue(60, got);
    chk("R6 launched", 32'(got), 32'd1);
    chk("R6 count", 32'(issue_count), 32'd32);
    chk("R6 nwarps", 32'(issue_nwarps), 32'd1);

    // R7 / R8 / R9: hold, head advance, warp id capture
    do_reset();
    push(96);
    alloc_warp_id = 8'd5; free_slots = 6'd1;
    wait_issue(20, got);
    chk("R9 first launch", 32'(got), 32'd1);
    chk("R9 warp id", 32'(issue_warp_id), 32'd5);
    chk("R8 first base", 32'(issue_base), 32'd0);
    alloc_warp_id = 8'd9; free_slots = 6'd3;
    repeat (2) @(negedge clk);
    chk("R7 valid held", 32'(issue_valid), 32'd1);
    chk("R7 count held", 32'(issue_count), 32'd32);
    chk("R7 id held", 32'(issue_warp_id), 32'd5);
    issue_ready = 1'b1;
    @(negedge clk);
    issue_ready = 1'b0;
    wait_issue(20, got);
    chk("R8 second launch", 32'(got), 32'd1);
    chk("R8 second base", 32'(issue_base), 32'd32);
    chk("R8 second count", 32'(issue_count), 32'd64);
    chk("R9 new warp id", 32'(issue_warp_id), 32'd9);
    read_at(32, d);
    chk("R8 order at base", d, 32'hC0DE_0020);

    // R2 / R3: fill past capacity with slots closed
    do_reset();
    push(1030);
    chk("R2 wr_ready low when full", 32'(wr_ready), 32'd0);
    chk("R2 overflow count", 32'(ovf_count), 32'd2);
    chk("R3 no launch without slots", 32'(issue_valid), 32'd0);
    read_at(1027, d);
    chk("R1 last entry", d, 32'hC0DE_0403);
    free_slots = 6'd1;
    wait_issue(20, got);
    chk("R3 launch once slot frees", 32'(got), 32'd1);
    issue_ready = 1'b1;
    @(negedge clk);
    issue_ready = 1'b0;
    chk("R2 wr_ready back", 32'(wr_ready), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule